// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which hardware interrupt the core should take next. It watches one non-maskable input and three maskable restart inputs. Two of the inputs (the non-maskable one and the highest-priority restart) are rising-edge sensitive and are held in edge latches. The other two restarts are level sensitive. The block presents the winning request to the core as a 16-bit vector address on a valid/ready channel.

The core configures the block through a one-cycle configuration write. That write carries three mask bits, a gate bit that must be set for the masks to change, a lock bit that blocks the mask update, and a bit that discards a latched high-priority edge. The core reads a status byte that shows the masks, the global enable and the three pending flags. Two pulse inputs set and clear the global enable, like the enable and disable instructions of the core. Each accepted vector clears the global enable and the edge latch of the source that was taken.

The vector channel follows these rules. `vec_valid` is high whenever some request qualifies. `vec_addr` always names the current winner, so it can move to a higher-priority vector while the core holds `vec_ready` low. `vec_valid` can drop before acceptance if a level request is withdrawn or the enable is cleared. A transfer takes place in any cycle where both `vec_valid` and `vec_ready` are high.

Top module: `prio_vec_intc`

## Requirements
- R1: While and after reset, all three masks are set, the global enable and both edge latches are clear, `vec_valid` is 0 and `stat_rd_data` reads 0x07.
- R2: A rising edge on `trap_in` is latched in the next cycle and yields vector 0x0024. This happens regardless of the global enable and the masks, and it takes priority over every maskable request.
- R3: Maskable requests are offered only while the global enable is 1 and their mask bit is 0. Priority runs high (vector 0x003C, mask bit 2), then mid (0x0034, mask bit 1), then low (0x002C, mask bit 0).
- R4: The mid and low requests are level sensitive. Their pending flags follow the inputs in the same cycle, and withdrawing the level withdraws the request.
- R5: A rising edge on `req_hi_in` is latched even while that source is masked or the enable is clear, and it stays visible in status bit 6.
- R6: A configuration write loads the masks from data bits 2:0 only when data bit 3 is 1 and data bit 6 is 0. Any other write leaves the masks unchanged.
- R7: A configuration write with data bit 4 set clears the high-priority edge latch, whatever bits 3 and 6 hold. A new rising edge in the same cycle wins, and the latch stays set.
- R8: The status byte holds masks in bits 2:0, the global enable in bit 3, the pending low, mid and high flags in bits 4, 5 and 6, and 0 in bit 7.
- R9: `ien_set` sets the global enable and `ien_clr` clears it. When both are high in the same cycle, the clear wins.
- R10: An accepted vector clears the global enable, even against `ien_set` in the same cycle. It also clears the edge latch of a taken trap or high request. It leaves the level requests untouched, and a new rising edge in the acceptance cycle keeps the latch set.
- R11: While `vec_ready` is low, a qualified request stays offered, and `vec_addr` follows the highest-priority qualified request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_in | input | 1 | Non-maskable request, rising-edge sensitive |
| req_lo_in | input | 1 | Low-priority restart, level sensitive |
| req_mid_in | input | 1 | Mid-priority restart, level sensitive |
| req_hi_in | input | 1 | High-priority restart, rising-edge sensitive |
| ien_set | input | 1 | Pulse: set global enable |
| ien_clr | input | 1 | Pulse: clear global enable |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| stat_rd_data | output | 8 | Status byte (masks, enable, pending flags) |
| vec_valid | output | 1 | A vector is offered |
| vec_ready | input | 1 | Core accepts the offered vector |
| vec_addr | output | 16 | Vector address of the current winner |

## Verification
The collisions that matter are a new rising edge meeting a clear of the same latch in one cycle. The clear can come from an acceptance or from the discard bit of a configuration write. The bench provokes each one by dropping the high input for a cycle and raising it again in exactly the cycle where `vec_ready` or the discard write is asserted. It then judges the result by status bit 6 and the offered vector in the following cycle. Enable set against clear, and enable set against acceptance, are collided the same way. A behavioural model predicts every output on every clock throughout.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_HI   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_LO   = 3'd4
  } pvic_src_e;

  localparam int CFG_W      = 8;
  localparam int MASK_W     = 3;
  localparam int BIT_GATE   = 3;
  localparam int BIT_HI_CLR = 4;
  localparam int BIT_LOCK   = 6;
  localparam int EDGE_N     = 2;
  localparam int EDGE_TRAP  = 0;
  localparam int EDGE_HI    = 1;
endpackage

// File: rtl/pvic_edge_latch.sv
module pvic_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic rise;

  assign rise = din & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= din;
      if (rise)      pend <= 1'b1;
      else if (clr)  pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pvic_ctrl_regs.sv
module pvic_ctrl_regs
  import pvic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_gate,
  input  logic              wr_lock,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              taken,
  output logic [MASK_W-1:0] mask_q,
  output logic              ien_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_en && wr_gate && !wr_lock) begin
      mask_q <= wr_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ien_q <= 1'b0;
    else if (taken || en_clr)   ien_q <= 1'b0;
    else if (en_set)            ien_q <= 1'b1;
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] TRAP_VEC = 'h24,
  parameter logic [ADDR_W-1:0] HI_VEC   = 'h3C,
  parameter logic [ADDR_W-1:0] MID_VEC  = 'h34,
  parameter logic [ADDR_W-1:0] LO_VEC   = 'h2C
) (
  input  logic              trap_p,
  input  logic              hi_p,
  input  logic              mid_p,
  input  logic              lo_p,
  input  logic [MASK_W-1:0] mask,
  input  logic              ien,
  output pvic_src_e         win,
  output logic              valid,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    win = SRC_NONE;
    if (trap_p)                         win = SRC_TRAP;
    else if (ien && hi_p  && !mask[2])  win = SRC_HI;
    else if (ien && mid_p && !mask[1])  win = SRC_MID;
    else if (ien && lo_p  && !mask[0])  win = SRC_LO;
  end

  always_comb begin
    case (win)
      SRC_TRAP: addr = TRAP_VEC;
      SRC_HI:   addr = HI_VEC;
      SRC_MID:  addr = MID_VEC;
      SRC_LO:   addr = LO_VEC;
      default:  addr = '0;
    endcase
  end

  assign valid = (win != SRC_NONE);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] TRAP_VEC = 'h24,
  parameter logic [ADDR_W-1:0] HI_VEC   = 'h3C,
  parameter logic [ADDR_W-1:0] MID_VEC  = 'h34,
  parameter logic [ADDR_W-1:0] LO_VEC   = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_in,
  input  logic              req_lo_in,
  input  logic              req_mid_in,
  input  logic              req_hi_in,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  stat_rd_data,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [EDGE_N-1:0] edge_in;
  logic [EDGE_N-1:0] edge_clr;
  logic [EDGE_N-1:0] edge_pend;
  logic [MASK_W-1:0] mask;
  logic              ien;
  logic              taken;
  pvic_src_e         win;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = cfg_wr_data[7] ^ cfg_wr_data[5];
  assign taken = vec_valid & vec_ready;

  assign edge_in[EDGE_TRAP]  = trap_in;
  assign edge_in[EDGE_HI]    = req_hi_in;
  assign edge_clr[EDGE_TRAP] = taken && (win == SRC_TRAP);
  assign edge_clr[EDGE_HI]   = (taken && (win == SRC_HI)) ||
                               (cfg_wr_en && cfg_wr_data[BIT_HI_CLR]);

  for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
    pvic_edge_latch u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (edge_in[g]),
      .clr  (edge_clr[g]),
      .pend (edge_pend[g])
    );
  end

  pvic_ctrl_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .wr_gate(cfg_wr_data[BIT_GATE]),
    .wr_lock(cfg_wr_data[BIT_LOCK]),
    .wr_mask(cfg_wr_data[MASK_W-1:0]),
    .en_set (ien_set),
    .en_clr (ien_clr),
    .taken  (taken),
    .mask_q (mask),
    .ien_q  (ien)
  );

  pvic_arbiter #(
    .ADDR_W  (ADDR_W),
    .TRAP_VEC(TRAP_VEC),
    .HI_VEC  (HI_VEC),
    .MID_VEC (MID_VEC),
    .LO_VEC  (LO_VEC)
  ) u_arb (
    .trap_p(edge_pend[EDGE_TRAP]),
    .hi_p  (edge_pend[EDGE_HI]),
    .mid_p (req_mid_in),
    .lo_p  (req_lo_in),
    .mask  (mask),
    .ien   (ien),
    .win   (win),
    .valid (vec_valid),
    .addr  (vec_addr)
  );

  assign stat_rd_data = {1'b0, edge_pend[EDGE_HI], req_mid_in, req_lo_in, ien, mask};
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] TRAP_VEC = 'h24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_in,
  input logic              req_hi_in,
  input logic              ien_set,
  input logic              ien_clr,
  input logic              cfg_wr_en,
  input logic [7:0]        cfg_wr_data,
  input logic [7:0]        stat_rd_data,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [ADDR_W-1:0] vec_addr
);
  a_r10_accept_drops_ien: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> !stat_rd_data[3]);

  a_r6_gated_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_data[3] && !cfg_wr_data[6]) |=> (stat_rd_data[2:0] == $past(cfg_wr_data[2:0])));

  a_r6_blocked_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en || !cfg_wr_data[3] || cfg_wr_data[6]) |=> $stable(stat_rd_data[2:0]));

  a_r3_maskable_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && (vec_addr != TRAP_VEC)) |-> stat_rd_data[3]);

  a_r5_hi_edge_captured: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_hi_in) |=> stat_rd_data[6]);

  a_r2_trap_offered: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_in) |=> (vec_valid && (vec_addr == TRAP_VEC)));

  a_r9_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && !ien_clr && !(vec_valid && vec_ready)) |=> stat_rd_data[3]);

  a_r8_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_data[7]);
endmodule

bind prio_vec_intc prio_vec_intc_chk #(
  .ADDR_W  (ADDR_W),
  .TRAP_VEC(TRAP_VEC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trap_in     (trap_in),
  .req_hi_in   (req_hi_in),
  .ien_set     (ien_set),
  .ien_clr     (ien_clr),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .stat_rd_data(stat_rd_data),
  .vec_valid   (vec_valid),
  .vec_ready   (vec_ready),
  .vec_addr    (vec_addr)
);

// File: tb/prio_vec_intc_bench.sv
`timescale 1ns/1ps
module prio_vec_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_in = 1'b0, req_lo_in = 1'b0, req_mid_in = 1'b0, req_hi_in = 1'b0;
  logic        ien_set = 1'b0, ien_clr = 1'b0, cfg_wr_en = 1'b0, vec_ready = 1'b0;
  logic [7:0]  cfg_wr_data = 8'h00;
  logic [7:0]  stat_rd_data;
  logic        vec_valid;
  logic [15:0] vec_addr;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // reference state
  bit       m_trap, m_hi, m_ien, p_trap, p_hi;
  bit [2:0] m_mask = 3'b111;
  int       e_win;
  bit       e_valid;
  bit [15:0] e_addr;
  bit [7:0]  e_stat;

  always #4 clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .req_lo_in(req_lo_in),
    .req_mid_in(req_mid_in), .req_hi_in(req_hi_in), .ien_set(ien_set),
    .ien_clr(ien_clr), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .stat_rd_data(stat_rd_data), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_addr(vec_addr)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic predict();
    e_win = 0;
    if (m_trap)                            e_win = 1;
    else if (m_ien && m_hi && !m_mask[2])  e_win = 2;
    else if (m_ien && req_mid_in && !m_mask[1]) e_win = 3;
    else if (m_ien && req_lo_in && !m_mask[0])  e_win = 4;
    e_valid = (e_win != 0);
    case (e_win)
      1: e_addr = 16'h0024;
      2: e_addr = 16'h003C;
      3: e_addr = 16'h0034;
      4: e_addr = 16'h002C;
      default: e_addr = 16'h0000;
    endcase
    e_stat = {1'b0, m_hi, req_mid_in, req_lo_in, m_ien, m_mask};
  endtask

  // one clock: compare just before the edge, then advance the model
  task automatic step();
    bit acc, rise_t, rise_h;
    #3;
    predict();
    check(cur_req, "vec_valid", {31'd0, vec_valid}, {31'd0, e_valid});
    if (e_valid) check(cur_req, "vec_addr", {16'd0, vec_addr}, {16'd0, e_addr});
    check(cur_req, "stat_rd_data", {24'd0, stat_rd_data}, {24'd0, e_stat});
    @(posedge clk);
    acc    = e_valid && vec_ready;
    rise_t = trap_in && !p_trap;
    rise_h = req_hi_in && !p_hi;
    if (rise_t) m_trap = 1'b1;
    else if (acc && e_win == 1) m_trap = 1'b0;
    if (rise_h) m_hi = 1'b1;
    else if ((acc && e_win == 2) || (cfg_wr_en && cfg_wr_data[4])) m_hi = 1'b0;
    if (cfg_wr_en && cfg_wr_data[3] && !cfg_wr_data[6]) m_mask = cfg_wr_data[2:0];
    if (acc || ien_clr) m_ien = 1'b0;
    else if (ien_set)   m_ien = 1'b1;
    p_trap = trap_in;
    p_hi   = req_hi_in;
    @(negedge clk);
  endtask

  task automatic cfg(logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    step();
    cfg_wr_en = 1'b0; cfg_wr_data = 8'h00;
  endtask

  task automatic enable();
    ien_set = 1'b1; step(); ien_set = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "stat in reset", {24'd0, stat_rd_data}, 32'h07);
    check("R1", "valid in reset", {31'd0, vec_valid}, 32'd0);
    rst_n = 1'b1;
    cur_req = "R1"; step();

    // R4 / R8: level request pending but masked, enable off
    cur_req = "R8"; req_lo_in = 1'b1; step(); step();
    check("R8", "stat low pending", {24'd0, stat_rd_data}, 32'h17);
    req_lo_in = 1'b0;

    // R6: locked write and ungated write ignored, then a real load
    cur_req = "R6"; cfg(8'h48); cfg(8'h00); step();
    check("R6", "masks kept", {29'd0, stat_rd_data[2:0]}, 32'h7);
    cfg(8'h08); step();

    // R9: set and clear together, then set alone
    cur_req = "R9"; ien_set = 1'b1; ien_clr = 1'b1; step();
    ien_set = 1'b0; ien_clr = 1'b0; step();
    check("R9", "clear wins", {31'd0, stat_rd_data[3]}, 32'd0);
    enable();

    // R3 / R11: priority ladder while the core stalls
    cur_req = "R3"; req_lo_in = 1'b1; step();
    check("R3", "low vector", {16'd0, vec_addr}, 32'h002C);
    req_mid_in = 1'b1; step();
    req_hi_in = 1'b1; step();
    cur_req = "R11"; step(); step();
    check("R11", "high vector held", {16'd0, vec_addr}, 32'h003C);
    cur_req = "R10"; vec_ready = 1'b1; ien_set = 1'b1; step();
    vec_ready = 1'b0; ien_set = 1'b0; step();
    check("R10", "enable cleared by accept", {31'd0, stat_rd_data[3]}, 32'd0);
    check("R10", "high latch cleared", {31'd0, stat_rd_data[6]}, 32'd0);
    req_hi_in = 1'b0;

    // R4: levels remain, withdrawing them withdraws the request
    cur_req = "R4"; enable(); step();
    req_mid_in = 1'b0; step();
    check("R4", "falls to low", {16'd0, vec_addr}, 32'h002C);
    req_lo_in = 1'b0; step();
    check("R4", "withdrawn", {31'd0, vec_valid}, 32'd0);

    // R2: trap with everything masked and enable off
    cur_req = "R2"; ien_clr = 1'b1; cfg(8'h0F); ien_clr = 1'b0;
    trap_in = 1'b1; step();
    check("R2", "trap vector", {16'd0, vec_addr}, 32'h0024);
    vec_ready = 1'b1; step(); vec_ready = 1'b0; trap_in = 1'b0; step();
    check("R2", "trap cleared", {31'd0, vec_valid}, 32'd0);

    // R2: trap beats high request
    cfg(8'h08); enable();
    trap_in = 1'b1; req_hi_in = 1'b1; step();
    check("R2", "trap over high", {16'd0, vec_addr}, 32'h0024);
    vec_ready = 1'b1; step(); vec_ready = 1'b0; trap_in = 1'b0;
    cur_req = "R10"; enable(); step();
    check("R10", "high after trap", {16'd0, vec_addr}, 32'h003C);

    // R10: new high edge in the accepting cycle keeps the latch
    req_hi_in = 1'b0; step();
    req_hi_in = 1'b1; vec_ready = 1'b1; step();
    vec_ready = 1'b0; step();
    check("R10", "latch survives accept", {31'd0, stat_rd_data[6]}, 32'd1);

    // R7: discard bit clears; with a simultaneous edge it does not
    cur_req = "R7"; cfg(8'h50); step();
    check("R7", "discarded", {31'd0, stat_rd_data[6]}, 32'd0);
    req_hi_in = 1'b0; step();
    req_hi_in = 1'b1; cfg(8'h10); step();
    check("R7", "edge beats discard", {31'd0, stat_rd_data[6]}, 32'd1);
    cfg(8'h10); req_hi_in = 1'b0;

    // R5: edge captured while masked and disabled
    cur_req = "R5"; ien_clr = 1'b1; cfg(8'h0F); ien_clr = 1'b0;
    req_hi_in = 1'b1; step(); step();
    check("R5", "masked edge visible", {24'd0, stat_rd_data}, 32'h47);
    check("R5", "not offered", {31'd0, vec_valid}, 32'd0);
    req_hi_in = 1'b0; cfg(8'h18);

    // mixed traffic, compared every cycle by the model
    cur_req = "R3";
    for (int i = 0; i < 600; i++) begin
      trap_in    = ($urandom_range(0, 15) == 0);
      req_lo_in  = $urandom_range(0, 1);
      req_mid_in = ($urandom_range(0, 3) == 0);
      req_hi_in  = ($urandom_range(0, 3) == 0);
      vec_ready  = ($urandom_range(0, 2) == 0);
      ien_set    = ($urandom_range(0, 3) == 0);
      ien_clr    = ($urandom_range(0, 9) == 0);
      cfg_wr_en  = ($urandom_range(0, 7) == 0);
      cfg_wr_data = 8'($urandom_range(0, 255));
      step();
    end
    cfg_wr_en = 1'b0; ien_set = 1'b0; ien_clr = 1'b0; vec_ready = 1'b0;
    step();
    finish_run();
  end
endmodule